// File: doc/BRIEF.md
# Input Supply Fault Monitor

This block watches two comparator flags for the input supply. Both flags are already synchronized to the clock. One flag reports an overvoltage and the other reports an undervoltage. The block turns each flag into a declared fault and applies its own time filter:

- **Overvoltage** is declared at once. It is withdrawn only after the input has stayed below the threshold for a programmable settling time.
- **Undervoltage** is declared only after the input has stayed low for a programmable qualification time. It is withdrawn as soon as the flag drops.

All times are counted in ticks of a one-microsecond strobe.

While overvoltage is declared, the block turns on the battery discharge switch. It also reports the live condition on a status code. Each time a fault becomes declared, the block sends one interrupt pulse of fixed length to the host. A sticky fault code records what happened. The host can clear that code only by reading it once the condition has gone away. A single-cycle read strobe, together with a register select, stands in for the host bus access.

Top module: `infault_monitor`

## Requirements
- R1: During and right after reset, fault_o and stat_o are 2'b00, and int_o and dischg_fet_o are 0.
- R2: A high ovp_cmp sampled at a clock edge makes the overvoltage declared from that edge onward. While it is declared, dischg_fet_o is 1 and stat_o is 2'b01.
- R3: Overvoltage stays declared until ovp_cmp has been low for OVP_CLR_US consecutive ticks. A return of ovp_cmp, even for one cycle, restarts that count.
- R4: Undervoltage becomes declared only after uvlo_cmp has been high for UVLO_SET_US consecutive ticks. A drop of uvlo_cmp restarts the count, and it also ends a declared undervoltage at the next edge. While undervoltage alone is declared, stat_o is 2'b10.
- R5: stat_o uses the code 00 for none, 01 for overvoltage and 10 for undervoltage. Overvoltage wins when both are declared, and 2'b11 never appears.
- R6: Each transition of either fault from not declared to declared raises int_o on the following cycle. int_o stays high until INT_US ticks have been seen, and it falls on the cycle after the last of those ticks.
- R7: A fault entry that happens while int_o is high neither restarts nor lengthens the pulse.
- R8: One cycle after stat_o shows a fault, fault_o takes the same code (01 overvoltage, 10 undervoltage, with overvoltage priority). fault_o keeps following the declared fault while any fault is declared.
- R9: Once no fault is declared, fault_o keeps its last code. The code clears to 2'b00 on the cycle after a read in which rd_stb=1 and rd_sel_fault=1 are sampled with no fault declared. A read taken while a fault is declared leaves fault_o unchanged, and so does a strobe with rd_sel_fault=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| ovp_cmp | input | 1 | Synchronized comparator flag: input above the overvoltage level |
| uvlo_cmp | input | 1 | Synchronized comparator flag: input below the undervoltage level |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_sel_fault | input | 1 | 1 when the read targets the fault register |
| fault_o | output | 2 | Sticky fault code |
| stat_o | output | 2 | Live fault status code |
| int_o | output | 1 | Interrupt pulse to the host |
| dischg_fet_o | output | 1 | Battery discharge switch enable |

## Verification
The bench builds the block with three shortened timers, all counted in ticks of a strobe that fires every fourth clock:

- overvoltage release after 20 ticks;
- undervoltage qualification after 12 ticks;
- a pulse of 8 ticks.

These values keep every deglitch window, restart and pulse end within a few hundred cycles. That makes it possible to drive a one-cycle overvoltage glitch in the middle of a release count, and an undervoltage dropout shorter than its qualification time. It also allows an overvoltage entry to land in the middle of an undervoltage pulse, and reads to be placed both before and after a fault has cleared.

// File: rtl/infault_pkg.sv
package infault_pkg;

    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_OVP  = 2'b01,
        FC_UVLO = 2'b10
    } fcode_e;

endpackage

// File: rtl/infault_dgl.sv
// Tick-counted filter: the flag sets after SET_TICKS consecutive ticks of a
// high raw input and clears after CLR_TICKS consecutive ticks of a low one.
// A count of zero makes that direction take effect at the next edge.
module infault_dgl #(
    parameter int SET_TICKS = 0,
    parameter int CLR_TICKS = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic flag_o
);
    localparam int MAXT     = (SET_TICKS > CLR_TICKS) ? SET_TICKS : CLR_TICKS;
    localparam int CW       = (MAXT > 1) ? $clog2(MAXT + 1) : 1;
    localparam logic [CW-1:0] SET_LAST = CW'((SET_TICKS > 0) ? SET_TICKS - 1 : 0);
    localparam logic [CW-1:0] CLR_LAST = CW'((CLR_TICKS > 0) ? CLR_TICKS - 1 : 0);

    typedef struct packed {
        logic          flag;
        logic [CW-1:0] cnt;
    } dgl_t;

    dgl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.flag) begin
            if (!raw_i) begin
                s_d.cnt = '0;
            end else if (SET_TICKS == 0) begin
                s_d.flag = 1'b1;
                s_d.cnt  = '0;
            end else if (tick_i) begin
                if (s_q.cnt == SET_LAST) begin
                    s_d.flag = 1'b1;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
        end else begin
            if (raw_i) begin
                s_d.cnt = '0;
            end else if (CLR_TICKS == 0) begin
                s_d.flag = 1'b0;
                s_d.cnt  = '0;
            end else if (tick_i) begin
                if (s_q.cnt == CLR_LAST) begin
                    s_d.flag = 1'b0;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;

endmodule

// File: rtl/infault_int_gen.sv
// One fixed-length pulse per fault entry; entries during a pulse are dropped.
module infault_int_gen #(
    parameter int PULSE_TICKS = 128,
    parameter int NSRC        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [NSRC-1:0] flags_i,
    output logic            int_o
);
    localparam int CW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

    typedef struct packed {
        logic            act;
        logic [NSRC-1:0] prev;
        logic [CW-1:0]   cnt;
    } ig_t;

    ig_t s_d, s_q;
    logic entry;

    always_comb begin
        s_d      = s_q;
        entry    = |(flags_i & ~s_q.prev);
        s_d.prev = flags_i;
        if (s_q.act) begin
            if (tick_i) begin
                if (s_q.cnt == LAST) begin
                    s_d.act = 1'b0;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
        end else if (entry) begin
            s_d.act = 1'b1;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign int_o = s_q.act;

endmodule

// File: rtl/infault_fault_reg.sv
// Sticky fault code: follows the declared fault, holds after, clears on read.
module infault_fault_reg
    import infault_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ovp_i,
    input  logic   uv_i,
    input  logic   rd_clr_i,
    output fcode_e fault_o
);
    typedef struct packed {
        fcode_e code;
    } fr_t;

    fr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ovp_i)         s_d.code = FC_OVP;
        else if (uv_i)     s_d.code = FC_UVLO;
        else if (rd_clr_i) s_d.code = FC_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{code: FC_NONE};
        else        s_q <= s_d;
    end

    assign fault_o = s_q.code;

endmodule

// File: rtl/infault_monitor.sv
module infault_monitor
    import infault_pkg::*;
#(
    parameter int OVP_CLR_US  = 30000,
    parameter int UVLO_SET_US = 10000,
    parameter int INT_US      = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       ovp_cmp,
    input  logic       uvlo_cmp,
    input  logic       rd_stb,
    input  logic       rd_sel_fault,
    output logic [1:0] fault_o,
    output logic [1:0] stat_o,
    output logic       int_o,
    output logic       dischg_fet_o
);
    logic   ovp_flag, uv_flag;
    fcode_e stat_c, fault_c;

    infault_dgl #(.SET_TICKS(0), .CLR_TICKS(OVP_CLR_US)) u_ovp_dgl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_us), .raw_i(ovp_cmp), .flag_o(ovp_flag)
    );

    infault_dgl #(.SET_TICKS(UVLO_SET_US), .CLR_TICKS(0)) u_uv_dgl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_us), .raw_i(uvlo_cmp), .flag_o(uv_flag)
    );

    infault_int_gen #(.PULSE_TICKS(INT_US), .NSRC(2)) u_int (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_us),
        .flags_i({uv_flag, ovp_flag}), .int_o(int_o)
    );

    infault_fault_reg u_freg (
        .clk(clk), .rst_n(rst_n), .ovp_i(ovp_flag), .uv_i(uv_flag),
        .rd_clr_i(rd_stb & rd_sel_fault), .fault_o(fault_c)
    );

    always_comb begin
        if (ovp_flag)     stat_c = FC_OVP;
        else if (uv_flag) stat_c = FC_UVLO;
        else              stat_c = FC_NONE;
    end

    assign stat_o       = stat_c;
    assign fault_o      = fault_c;
    assign dischg_fet_o = ovp_flag;

endmodule

// File: rtl/infault_monitor_chk.sv
module infault_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ovp_cmp,
    input logic       uvlo_cmp,
    input logic       rd_stb,
    input logic       rd_sel_fault,
    input logic [1:0] fault_o,
    input logic [1:0] stat_o,
    input logic       int_o,
    input logic       dischg_fet_o
);
    // R2
    ovp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_cmp |=> (stat_o == 2'b01 && dischg_fet_o));

    // R5
    stat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o != 2'b11);

    // R4
    quiet_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovp_cmp && !uvlo_cmp && stat_o == 2'b00) |=> stat_o == 2'b00);

    // R6
    int_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_o) |-> fault_o != 2'b00);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel_fault && stat_o == 2'b00) |=> fault_o == 2'b00);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o != 2'b00 && !(rd_stb && rd_sel_fault)) |=> fault_o != 2'b00);

endmodule

bind infault_monitor infault_monitor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ovp_cmp(ovp_cmp), .uvlo_cmp(uvlo_cmp),
    .rd_stb(rd_stb), .rd_sel_fault(rd_sel_fault), .fault_o(fault_o),
    .stat_o(stat_o), .int_o(int_o), .dischg_fet_o(dischg_fet_o)
);

// File: tb/infault_monitor_bench.sv
`timescale 1ns/1ps
module infault_monitor_bench;
    localparam int OVP_T = 20;
    localparam int UV_T  = 12;
    localparam int INT_T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic ovp_cmp = 1'b0, uvlo_cmp = 1'b0, rd_stb = 1'b0, rd_sel_fault = 1'b0;
    logic [1:0] fault_o, stat_o;
    logic int_o, dischg_fet_o;

    int checks = 0, errors = 0, cyc = 0, tdiv = 0;
    int rises = 0, hi_len = 0, last_len = 0;
    logic prev_int = 1'b0;
    bit done = 1'b0;

    // reference state
    int m_ovp = 0, m_ovp_cnt = 0, m_uv = 0, m_uv_cnt = 0;
    int m_ovp_was = 0, m_uv_was = 0, m_int = 0, m_int_cnt = 0, m_fault = 0;

    always #5 clk = ~clk;

    infault_monitor #(.OVP_CLR_US(OVP_T), .UVLO_SET_US(UV_T), .INT_US(INT_T)) u_infault_monitor (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ovp_cmp(ovp_cmp), .uvlo_cmp(uvlo_cmp),
        .rd_stb(rd_stb), .rd_sel_fault(rd_sel_fault), .fault_o(fault_o), .stat_o(stat_o),
        .int_o(int_o), .dischg_fet_o(dischg_fet_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // tick every fourth cycle
    always @(negedge clk) begin
        tdiv    <= (tdiv + 1) % 4;
        tick_us <= (tdiv == 3);
    end

    // behavioural reference, stepped at each edge from the requirements
    always @(posedge clk) begin
        int n_ovp, n_uv, n_fault, entered;
        if (!rst_n) begin
            m_ovp = 0; m_ovp_cnt = 0; m_uv = 0; m_uv_cnt = 0;
            m_ovp_was = 0; m_uv_was = 0; m_int = 0; m_int_cnt = 0; m_fault = 0;
        end else begin
            n_ovp = m_ovp;
            if (ovp_cmp) begin n_ovp = 1; m_ovp_cnt = 0; end
            else if (m_ovp == 1 && tick_us) begin
                m_ovp_cnt++;
                if (m_ovp_cnt == OVP_T) begin n_ovp = 0; m_ovp_cnt = 0; end
            end
            n_uv = m_uv;
            if (!uvlo_cmp) begin n_uv = 0; m_uv_cnt = 0; end
            else if (m_uv == 0 && tick_us) begin
                m_uv_cnt++;
                if (m_uv_cnt == UV_T) begin n_uv = 1; m_uv_cnt = 0; end
            end
            n_fault = m_fault;
            if (m_ovp == 1) n_fault = 1;
            else if (m_uv == 1) n_fault = 2;
            else if (rd_stb && rd_sel_fault) n_fault = 0;
            entered = ((m_ovp == 1 && m_ovp_was == 0) || (m_uv == 1 && m_uv_was == 0)) ? 1 : 0;
            if (m_int == 1) begin
                if (tick_us) begin
                    m_int_cnt++;
                    if (m_int_cnt == INT_T) begin m_int = 0; m_int_cnt = 0; end
                end
            end else if (entered == 1) begin
                m_int = 1; m_int_cnt = 0;
            end
            m_ovp_was = m_ovp; m_uv_was = m_uv;
            m_ovp = n_ovp; m_uv = n_uv; m_fault = n_fault;
        end
    end

    // per-cycle comparison, pulse measurement, watchdog
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R5 stat", int'(stat_o), (m_ovp == 1) ? 1 : ((m_uv == 1) ? 2 : 0));
            chk("R2 dischg", int'(dischg_fet_o), m_ovp);
            chk("R8 fault", int'(fault_o), m_fault);
            chk("R6 int", int'(int_o), m_int);
            if (int_o && !prev_int) rises++;
            if (int_o) hi_len++;
            else if (prev_int) begin last_len = hi_len; hi_len = 0; end
            prev_int = int_o;
        end
        if (cyc > 20000) begin
            chk("watchdog", 1, 0);
            finish_run();
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic sel);
        @(negedge clk); rd_stb = 1'b1; rd_sel_fault = sel;
        @(negedge clk); rd_stb = 1'b0; rd_sel_fault = 1'b0;
    endtask

    initial begin
        int r0;
        int guard;
        wait_n(3);
        // R1 reset values
        chk("R1 fault", int'(fault_o), 0);
        chk("R1 stat", int'(stat_o), 0);
        chk("R1 int", int'(int_o), 0);
        chk("R1 dischg", int'(dischg_fet_o), 0);
        rst_n = 1'b1;
        wait_n(4);

        // overvoltage entry
        ovp_cmp = 1'b1;
        wait_n(2);
        chk("R2 stat ovp", int'(stat_o), 1);
        chk("R2 dischg on", int'(dischg_fet_o), 1);
        wait_n(40);
        chk("R6 one pulse", rises, 1);
        chk("R6 width in range", (last_len >= 29 && last_len <= 32) ? 1 : 0, 1);
        do_read(1'b1);
        wait_n(1);
        chk("R9 read while active", int'(fault_o), 1);

        // release with a glitch mid-count
        ovp_cmp = 1'b0;
        wait_n(40);
        ovp_cmp = 1'b1;
        wait_n(1);
        ovp_cmp = 1'b0;
        wait_n(60);
        chk("R3 glitch restarts", int'(stat_o), 1);
        wait_n(40);
        chk("R3 released", int'(stat_o), 0);
        chk("R3 dischg off", int'(dischg_fet_o), 0);
        chk("R9 sticky", int'(fault_o), 1);
        chk("R7 no extra pulse", rises, 1);
        do_read(1'b0);
        wait_n(1);
        chk("R9 other select", int'(fault_o), 1);
        do_read(1'b1);
        wait_n(1);
        chk("R9 cleared", int'(fault_o), 0);

        // short undervoltage dip does not qualify
        uvlo_cmp = 1'b1;
        wait_n(32);
        uvlo_cmp = 1'b0;
        wait_n(5);
        chk("R4 short dip", int'(stat_o), 0);
        chk("R4 short dip int", rises, 1);

        // qualified undervoltage
        uvlo_cmp = 1'b1;
        wait_n(60);
        chk("R4 declared", int'(stat_o), 2);
        chk("R8 uvlo code", int'(fault_o), 2);
        wait_n(40);
        chk("R6 uvlo pulse", rises, 2);
        uvlo_cmp = 1'b0;
        wait_n(2);
        chk("R4 drop", int'(stat_o), 0);

        // overvoltage entry inside an undervoltage pulse
        r0 = rises;
        uvlo_cmp = 1'b1;
        guard = 0;
        while (!int_o && guard < 200) begin @(negedge clk); guard++; end
        wait_n(8);
        ovp_cmp = 1'b1;
        wait_n(2);
        chk("R5 ovp priority", int'(stat_o), 1);
        wait_n(1);
        chk("R8 ovp priority", int'(fault_o), 1);
        wait_n(60);
        chk("R7 no retrigger", rises - r0, 1);
        ovp_cmp = 1'b0;
        uvlo_cmp = 1'b0;
        wait_n(100);
        chk("R3 both gone", int'(stat_o), 0);
        do_read(1'b1);
        wait_n(1);
        chk("R9 final clear", int'(fault_o), 0);
        finish_run();
    end
endmodule